// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex serial port that moves characters over a single data line in each direction, with no shared clock between the two ends. Each character travels as a frame. The frame opens with one low start bit. The character bits follow, least significant first. An optional parity bit comes next, and one or two high stop bits close the frame. A two-bit mode input selects 8-bit characters (`2'b11`) or 7-bit characters (`2'b10`). Any other code parks the port.

Bit timing is built from an oversampling tick, sixteen ticks to one bit. The tick is taken either from an internal rate-generator pulse input or from the rising edges of an external serial-clock pin, as chosen by a select input. The host writes characters into a two-entry transmit buffer and reads received characters from a four-entry FIFO. Sticky flags report parity, framing and overrun errors.

The transmit and receive paths share only the tick and the configuration, so both can run at the same time.

Top module: `sio_async_port`

## Requirements
- R1: Mode `2'b11` selects 8-bit characters and `2'b10` selects 7-bit characters. With any other mode code, `sout` stays high, `tx_wr` writes are discarded and `sin` activity stores nothing.
- R2: A transmitted frame is sent in this order: a low start bit, then the character from bit 0 upward, then the parity bit when enabled, then one stop bit (`two_stop`=0) or two stop bits (`two_stop`=1), all high. Each bit lasts 16 oversampling ticks.
- R3: With `par_en`=1, the parity bit makes the count of ones over data plus parity even when `par_odd`=0, and odd when `par_odd`=1. With `par_en`=0 no parity bit is sent or expected.
- R4: The transmit buffer holds two characters, and `tx_full` is high while two are pending. A write while `tx_full` is high is dropped. Buffered characters go out back to back with no idle time between frames.
- R5: The receiver starts on a falling edge of `sin` and confirms the start bit on the 8th tick. A low pulse shorter than half a bit is ignored. Each later bit is sampled 16 ticks after the previous sample.
- R6: The receive FIFO holds four characters in arrival order. `rx_data` shows the oldest one, `rx_avail` is high while any are held, and a one-cycle `rx_rd` pulse removes the oldest.
- R7: A received parity bit that does not match the data sets `err_parity`, which stays high. The character is still stored.
- R8: Any stop bit sampled low sets `err_frame`, which stays high. The character is still stored.
- R9: A character completed while the FIFO holds four is dropped and sets `err_overrun`, which stays high. An `err_clr` pulse clears all three error flags.
- R10: In 7-bit mode, received characters are stored with bit 7 at 0, and bit 7 of a written character is not sent and does not enter the parity.
- R11: With `use_ext_clk`=0, each cycle with `int_tick` high is one oversampling tick. With `use_ext_clk`=1, each rising edge of `ext_sclk` is one tick, seen after a two-flop synchronizer.
- R12: Transmit and receive run at the same time without disturbing each other.
- R13: After reset, `sout` is high, both buffers are empty, `tx_full`, `rx_avail` and `rx_full` are low, and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | 11: 8-bit frames, 10: 7-bit frames, others: port parked |
| two_stop | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| use_ext_clk | input | 1 | 1 takes ticks from `ext_sclk` edges, 0 takes them from `int_tick` |
| int_tick | input | 1 | Internal oversampling tick, one cycle wide |
| ext_sclk | input | 1 | External serial clock pin |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit buffer holds two characters |
| rx_rd | input | 1 | Pop strobe for the receive FIFO |
| rx_data | output | 8 | Oldest received character |
| rx_avail | output | 1 | Receive FIFO is not empty |
| rx_full | output | 1 | Receive FIFO holds four characters |
| err_clr | input | 1 | Clears the sticky error flags |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| sin | input | 1 | Serial data in, idle high |
| sout | output | 1 | Serial data out, idle high |

## Verification
A written character goes into the buffer on the first clock edge and into the shifter on the second. The start bit therefore appears on `sout` two edges after the write. The bench watches for that falling edge, waits half a bit, and then samples once per bit period, 32 clocks with the internal tick and 64 with the external clock. Because it samples continuously across frames, any idle gap between back-to-back frames shows up as a mismatch in the expected start bit. A received character, together with its error flags, is written into the FIFO one clock after the tick that samples the last stop bit at mid-bit. The bench checks `rx_data` and the flags only after it has driven the whole frame and waited four more clocks, and it does so before the next frame starts.

// File: rtl/sio_pkg.sv
// Shared types and helpers for the asynchronous serial transceiver.
// Assumes characters are at most eight bits wide.
package sio_pkg;

    localparam int MAX_DATA = 8;
    // start + data + parity + two stop bits
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;

    localparam logic [1:0] MODE_CHAR8 = 2'b11;
    localparam logic [1:0] MODE_CHAR7 = 2'b10;

    // Decoded line configuration shared by both directions.
    typedef struct packed {
        logic en;        // an asynchronous mode is selected
        logic eight;     // 8-bit characters when set, 7-bit otherwise
        logic two_stop;  // two stop bits
        logic par_en;    // parity bit present
        logic par_odd;   // odd parity when set
    } frame_cfg_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    // Parity bit for a character that has already been masked to its width.
    function automatic logic sio_parity(logic [MAX_DATA-1:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sio_tick_sel.sv
// Oversampling tick source.
// Passes through the internal tick, or turns rising edges of the external
// serial clock into single-cycle ticks. The external pin is assumed to be
// asynchronous and slower than clk / 2.
module sio_tick_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_ext,
    input  logic int_tick,
    input  logic ext_sclk,
    output logic os_tick
);

    logic [SYNC_STAGES:0] ext_sr;
    logic                 ext_rise;

    // Synchronizer chain with one extra stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sr <= '0;
        else        ext_sr <= {ext_sr[SYNC_STAGES-1:0], ext_sclk};
    end

    assign ext_rise = ext_sr[SYNC_STAGES-1] & ~ext_sr[SYNC_STAGES];

    // Register the chosen tick so both sources see the same latency.
    always_ff @(posedge clk) begin
        if (!rst_n) os_tick <= 1'b0;
        else        os_tick <= use_ext ? ext_rise : int_tick;
    end

    // R11
    ext_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && $past(use_ext) && os_tick) |=> !os_tick);

endmodule

// File: rtl/sio_fifo.sv
// Small synchronous FIFO with full/empty flags.
// Writes into a full FIFO and reads from an empty one are ignored.
// rd_data shows the oldest entry without a read strobe.
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R4
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (cnt == $past(cnt)));

    // R6
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> empty);

endmodule

// File: rtl/sio_tx.sv
// Transmit framer and shifter.
// Builds start, data, optional parity and stop bits into one shift register
// and shifts it out LSB first, one bit per OSR ticks. When the last bit of a
// frame ends and the buffer has more, the next frame is loaded in the same
// cycle. Leaving the asynchronous modes aborts a frame and parks the line high.
module sio_tx
    import sio_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  frame_cfg_t          cfg,
    input  logic                os_tick,
    input  logic                buf_empty,
    input  logic [MAX_DATA-1:0] buf_data,
    output logic                buf_pop,
    output logic                sout
);

    localparam int TW = $clog2(OSR);

    logic [FRAME_W-1:0]  shreg;
    logic [FRAME_W-1:0]  frame;
    logic [3:0]          nbits;
    logic [3:0]          bits_left;
    logic [TW-1:0]       tcnt;
    logic                busy;
    logic                end_bit;
    logic                last_bit;
    logic                start_ok;
    logic [MAX_DATA-1:0] dm;

    // Assemble the frame for the character at the buffer head.
    always_comb begin
        dm    = cfg.eight ? buf_data : {1'b0, buf_data[MAX_DATA-2:0]};
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < MAX_DATA - 1 || cfg.eight) frame[1+i] = dm[i];
        end
        if (cfg.par_en) begin
            if (cfg.eight) frame[MAX_DATA+1] = sio_parity(dm, cfg.par_odd);
            else           frame[MAX_DATA]   = sio_parity(dm, cfg.par_odd);
        end
        nbits = 4'd9 + {3'b0, cfg.eight} + {3'b0, cfg.par_en} + {3'b0, cfg.two_stop};
    end

    assign end_bit  = busy && os_tick && (tcnt == TW'(OSR-1));
    assign last_bit = end_bit && (bits_left == 4'd1);
    assign start_ok = cfg.en && !buf_empty && (!busy || last_bit);
    assign buf_pop  = start_ok;
    assign sout     = shreg[0];

    // Frame sequencing: load, bit timing, shift and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
            busy      <= 1'b0;
        end else if (!cfg.en) begin
            shreg     <= '1;
            bits_left <= '0;
            tcnt      <= '0;
            busy      <= 1'b0;
        end else if (start_ok) begin
            shreg     <= frame;
            bits_left <= nbits;
            tcnt      <= '0;
            busy      <= 1'b1;
        end else if (end_bit) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 1'b1;
            tcnt      <= '0;
            if (last_bit) busy <= 1'b0;
        end else if (busy && os_tick) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R1
    tx_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> sout);

    // R4
    tx_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !buf_empty && cfg.en) |=> (busy && !sout));

    // R2
    tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && !os_tick && !start_ok) |=> $stable(sout));

endmodule

// File: rtl/sio_rx.sv
// Receive sampler and deframer.
// Synchronizes the line, waits for a falling edge, confirms the start bit at
// half a bit, then samples each later bit at its centre. On the last stop
// bit it emits a one-cycle push with the character and its error status.
// Assumes the tick rate is well below the clock rate.
module sio_rx
    import sio_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  frame_cfg_t          cfg,
    input  logic                os_tick,
    input  logic                sin,
    output logic                push,
    output logic [MAX_DATA-1:0] pdata,
    output logic                perr_set,
    output logic                ferr_set
);

    localparam int TW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    rx_state_t           state;
    logic [1:0]          sync;
    logic                rx_s;
    logic                rx_prev;
    logic [TW-1:0]       tcnt;
    logic [2:0]          idx;
    logic [2:0]          last_idx;
    logic                stop2;
    logic                pbad;
    logic                fbad;
    logic                half_pt;
    logic                full_pt;

    assign rx_s     = sync[1];
    assign half_pt  = os_tick && (tcnt == TW'(HALF-1));
    assign full_pt  = os_tick && (tcnt == TW'(OSR-1));
    assign last_idx = cfg.eight ? 3'd7 : 3'd6;

    // Line synchronizer and previous-level register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync    <= 2'b11;
            rx_prev <= 1'b1;
        end else begin
            sync    <= {sync[0], sin};
            rx_prev <= rx_s;
        end
    end

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            tcnt     <= '0;
            idx      <= '0;
            stop2    <= 1'b0;
            pbad     <= 1'b0;
            fbad     <= 1'b0;
            pdata    <= '0;
            push     <= 1'b0;
            perr_set <= 1'b0;
            ferr_set <= 1'b0;
        end else begin
            push     <= 1'b0;
            perr_set <= 1'b0;
            ferr_set <= 1'b0;
            if (!cfg.en) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: begin
                        if (rx_prev && !rx_s) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (half_pt) begin
                            tcnt <= '0;
                            if (!rx_s) begin
                                state <= RX_DATA;
                                idx   <= '0;
                                pdata <= '0;
                                pbad  <= 1'b0;
                                fbad  <= 1'b0;
                                stop2 <= 1'b0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (full_pt) begin
                            tcnt       <= '0;
                            pdata[idx] <= rx_s;
                            if (idx == last_idx) state <= cfg.par_en ? RX_PAR : RX_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (full_pt) begin
                            tcnt  <= '0;
                            pbad  <= (rx_s != sio_parity(pdata, cfg.par_odd));
                            state <= RX_STOP;
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (full_pt) begin
                            tcnt <= '0;
                            if (cfg.two_stop && !stop2) begin
                                stop2 <= 1'b1;
                                fbad  <= fbad | !rx_s;
                            end else begin
                                push     <= 1'b1;
                                perr_set <= pbad;
                                ferr_set <= fbad | !rx_s;
                                state    <= RX_IDLE;
                            end
                        end else if (os_tick) begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R1
    rx_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> (state == RX_IDLE && !push));

    // R2
    rx_push_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(state == RX_STOP));

    // R8
    rx_ferr_with_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_set |-> push);

endmodule

// File: rtl/sio_async_port.sv
// Top of the asynchronous serial transceiver.
// Decodes the line configuration, selects the tick source, and wires a
// two-entry transmit buffer into the framer and the deframer into a
// four-entry receive FIFO. It also keeps the sticky error flags.
// Configuration inputs are assumed stable while a frame is in flight.
module sio_async_port
    import sio_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int TX_DEPTH = 2,
    parameter int RX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       two_stop,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       use_ext_clk,
    input  logic       int_tick,
    input  logic       ext_sclk,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    output logic       tx_full,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_avail,
    output logic       rx_full,
    input  logic       err_clr,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    input  logic       sin,
    output logic       sout
);

    frame_cfg_t          cfg;
    logic                os_tick;
    logic                tx_empty;
    logic                tx_pop;
    logic [MAX_DATA-1:0] tx_head;
    logic                rx_push;
    logic [MAX_DATA-1:0] rx_byte;
    logic                rx_perr;
    logic                rx_ferr;
    logic                rx_empty;

    // Decode the mode and framing inputs.
    always_comb begin
        cfg.en       = (mode == MODE_CHAR8) || (mode == MODE_CHAR7);
        cfg.eight    = (mode == MODE_CHAR8);
        cfg.two_stop = two_stop;
        cfg.par_en   = par_en;
        cfg.par_odd  = par_odd;
    end

    sio_tick_sel #(.SYNC_STAGES(2)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_ext  (use_ext_clk),
        .int_tick (int_tick),
        .ext_sclk (ext_sclk),
        .os_tick  (os_tick)
    );

    sio_fifo #(.W(MAX_DATA), .DEPTH(TX_DEPTH)) u_tx_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_wr && cfg.en),
        .wr_data (tx_data),
        .rd_en   (tx_pop),
        .rd_data (tx_head),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    sio_tx #(.OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .os_tick   (os_tick),
        .buf_empty (tx_empty),
        .buf_data  (tx_head),
        .buf_pop   (tx_pop),
        .sout      (sout)
    );

    sio_rx #(.OSR(OSR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .os_tick  (os_tick),
        .sin      (sin),
        .push     (rx_push),
        .pdata    (rx_byte),
        .perr_set (rx_perr),
        .ferr_set (rx_ferr)
    );

    sio_fifo #(.W(MAX_DATA), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push),
        .wr_data (rx_byte),
        .rd_en   (rx_rd),
        .rd_data (rx_data),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    assign rx_avail = !rx_empty;

    // Sticky error flags; a new error in the clear cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            err_parity  <= (err_parity  && !err_clr) || (rx_push && rx_perr);
            err_frame   <= (err_frame   && !err_clr) || (rx_push && rx_ferr);
            err_overrun <= (err_overrun && !err_clr) || (rx_push && rx_full);
        end
    end

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_push && rx_full));

    // R9
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !rx_push) |=> (!err_parity && !err_frame && !err_overrun));

    // R7
    perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity);

endmodule

// File: tb/sio_async_port_bench.sv
`timescale 1ns/1ps
module sio_async_port_bench;

    localparam int TDIV     = 2;
    localparam int BIT_INT  = 16 * TDIV;
    localparam int EXT_HALF = 2;
    localparam int BIT_EXT  = 16 * 2 * EXT_HALF;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       two_stop, par_en, par_odd, use_ext_clk;
    logic       int_tick, ext_sclk;
    logic       tx_wr;
    logic [7:0] tx_data;
    logic       tx_full;
    logic       rx_rd;
    logic [7:0] rx_data;
    logic       rx_avail, rx_full;
    logic       err_clr, err_parity, err_frame, err_overrun;
    logic       sin, sout;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sio_async_port u_sio_async_port (
        .clk(clk), .rst_n(rst_n), .mode(mode), .two_stop(two_stop),
        .par_en(par_en), .par_odd(par_odd), .use_ext_clk(use_ext_clk),
        .int_tick(int_tick), .ext_sclk(ext_sclk), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_avail(rx_avail), .rx_full(rx_full),
        .err_clr(err_clr), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .sin(sin), .sout(sout)
    );

    // Internal tick: one cycle in every TDIV.
    initial begin
        int c = 0;
        int_tick = 1'b0;
        forever begin
            @(negedge clk);
            c++;
            int_tick = ((c % TDIV) == 0);
        end
    end

    // External serial clock, period 2*EXT_HALF cycles.
    initial begin
        ext_sclk = 1'b0;
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            ext_sclk = ~ext_sclk;
        end
    end

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input bit eight, input bit pe, input bit ts);
        return 9 + int'(eight) + int'(pe) + int'(ts);
    endfunction

    // Expected line bits, LSB first, for one character.
    function automatic logic [11:0] mk_frame(input bit eight, input bit pe, input bit po,
                                             input bit ts, input logic [7:0] d);
        logic [11:0] f;
        logic [7:0]  m;
        int          p;
        m = eight ? d : (d & 8'h7f);
        f = '0;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) if (i < 7 || eight) f[1+i] = m[i];
        p = eight ? 9 : 8;
        if (pe) begin
            f[p] = (^m) ^ po;
            p++;
        end
        f[p] = 1'b1;
        if (ts) f[p+1] = 1'b1;
        return f;
    endfunction

    task automatic set_cfg(input logic [1:0] m, input bit ts, input bit pe,
                           input bit po, input bit ue);
        @(negedge clk);
        mode = m; two_stop = ts; par_en = pe; par_odd = po; use_ext_clk = ue;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_tx(input logic [7:0] d);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // Capture nf*nb consecutive bits from sout starting at the next start bit.
    task automatic grab_tx(input int nf, input int nb, input int bitclk,
                           output logic [47:0] got);
        int t = 0;
        got = '0;
        while (sout !== 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (bitclk / 2) @(negedge clk);
        for (int k = 0; k < nf * nb; k++) begin
            got[k] = sout;
            repeat (bitclk) @(negedge clk);
        end
    endtask

    task automatic drive_rx(input logic [11:0] bits, input int nb, input int bitclk);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            sin = bits[k];
            repeat (bitclk - 1) @(negedge clk);
        end
        @(negedge clk);
        sin = 1'b1;
    endtask

    task automatic expect_rx(input string req, input logic [7:0] e);
        chk({req, " avail"}, 48'(rx_avail), 48'd1);
        chk(req, 48'(rx_data), 48'(e));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic clear_flags();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch_idle(input int ncyc, output int lows);
        lows = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (sout !== 1'b1) lows++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL R13 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [47:0] got;
        logic [47:0] exp;
        logic [11:0] f;
        logic [7:0]  bytes [5];
        int          nb, lows, seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; mode = 2'b11; two_stop = 0; par_en = 0; par_odd = 0;
        use_ext_clk = 0; tx_wr = 0; tx_data = '0; rx_rd = 0; err_clr = 0; sin = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk("R13 sout", 48'(sout), 48'd1);
        chk("R13 tx_full", 48'(tx_full), 48'd0);
        chk("R13 rx_avail", 48'(rx_avail), 48'd0);
        chk("R13 rx_full", 48'(rx_full), 48'd0);
        chk("R13 flags", 48'({err_parity, err_frame, err_overrun}), 48'd0);

        // Random full-duplex frames over all framing variants (R2 R3 R10 R12).
        for (int it = 0; it < 24; it++) begin
            bit          eight, ts, pe, po;
            logic [7:0]  txd, rxd;
            eight = $urandom % 2; ts = $urandom % 2; pe = $urandom % 2; po = $urandom % 2;
            txd = 8'($urandom); rxd = 8'($urandom);
            set_cfg(eight ? 2'b11 : 2'b10, ts, pe, po, 1'b0);
            nb = frame_len(eight, pe, ts);
            write_tx(txd);
            fork
                grab_tx(1, nb, BIT_INT, got);
                drive_rx(mk_frame(eight, pe, po, ts, rxd), nb, BIT_INT);
            join
            repeat (4) @(negedge clk);
            chk("R2 R3 R10 R12 tx frame", got, 48'(mk_frame(eight, pe, po, ts, txd)));
            expect_rx("R6 R10 R12 rx byte", eight ? rxd : (rxd & 8'h7f));
            chk("R3 no false errors", 48'({err_parity, err_frame, err_overrun}), 48'd0);
        end

        // R10 directed: bit 7 ignored in 7-bit mode both ways.
        set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        nb = frame_len(0, 1, 0);
        write_tx(8'hff);
        f = mk_frame(0, 1, 0, 0, 8'h7f);
        fork
            grab_tx(1, nb, BIT_INT, got);
            drive_rx(f, nb, BIT_INT);
        join
        repeat (4) @(negedge clk);
        chk("R10 tx bit7 dropped", got, 48'(f));
        expect_rx("R10 rx bit7 zero", 8'h7f);

        // R4 buffer depth, dropped write, back-to-back frames.
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        nb = 10;
        write_tx(8'h11);
        write_tx(8'h22);
        write_tx(8'h33);
        chk("R4 tx_full after two pending", 48'(tx_full), 48'd1);
        write_tx(8'h44);
        chk("R4 tx_full holds", 48'(tx_full), 48'd1);
        grab_tx(3, nb, BIT_INT, got);
        exp = 48'(mk_frame(1, 0, 0, 0, 8'h11))
            | (48'(mk_frame(1, 0, 0, 0, 8'h22)) << 10)
            | (48'(mk_frame(1, 0, 0, 0, 8'h33)) << 20);
        chk("R4 three gapless frames", got, exp);
        watch_idle(400, lows);
        chk("R4 write while full dropped", 48'(lows), 48'd0);

        // R7 parity error, sticky, byte kept.
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        nb = frame_len(1, 1, 0);
        f = mk_frame(1, 1, 0, 0, 8'h5a);
        f[9] = ~f[9];
        drive_rx(f, nb, BIT_INT);
        repeat (4) @(negedge clk);
        chk("R7 err_parity set", 48'(err_parity), 48'd1);
        chk("R7 err_frame clear", 48'(err_frame), 48'd0);
        drive_rx(mk_frame(1, 1, 0, 0, 8'h3c), nb, BIT_INT);
        repeat (4) @(negedge clk);
        chk("R7 err_parity sticky", 48'(err_parity), 48'd1);
        expect_rx("R7 bad byte stored", 8'h5a);
        expect_rx("R7 next byte", 8'h3c);
        clear_flags();
        chk("R9 clear parity flag", 48'(err_parity), 48'd0);

        // R8 framing error on the second stop bit, 7-bit two stops.
        set_cfg(2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
        nb = frame_len(0, 0, 1);
        f = mk_frame(0, 0, 0, 1, 8'h15);
        f[nb-1] = 1'b0;
        drive_rx(f, nb, BIT_INT);
        repeat (4) @(negedge clk);
        chk("R8 err_frame set", 48'(err_frame), 48'd1);
        expect_rx("R8 byte stored", 8'h15);
        clear_flags();
        chk("R9 clear frame flag", 48'(err_frame), 48'd0);

        // R9 overrun: fifth byte dropped, first four kept in order (R6).
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        nb = 10;
        for (int k = 0; k < 5; k++) begin
            bytes[k] = 8'($urandom);
            drive_rx(mk_frame(1, 0, 0, 0, bytes[k]), nb, BIT_INT);
        end
        repeat (4) @(negedge clk);
        chk("R6 rx_full", 48'(rx_full), 48'd1);
        chk("R9 err_overrun", 48'(err_overrun), 48'd1);
        for (int k = 0; k < 4; k++) expect_rx("R6 fifo order", bytes[k]);
        chk("R9 fifth dropped", 48'(rx_avail), 48'd0);
        clear_flags();
        chk("R9 clear overrun", 48'(err_overrun), 48'd0);

        // R5 short low glitch ignored.
        @(negedge clk);
        sin = 1'b0;
        repeat (BIT_INT / 4) @(negedge clk);
        sin = 1'b1;
        repeat (400) @(negedge clk);
        chk("R5 glitch ignored", 48'(rx_avail), 48'd0);

        // R1 parked mode: no output, writes and input ignored.
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        write_tx(8'h00);
        fork
            watch_idle(400, lows);
            drive_rx(mk_frame(1, 0, 0, 0, 8'ha5), 10, BIT_INT);
        join
        chk("R1 sout parked", 48'(lows), 48'd0);
        chk("R1 rx ignored", 48'(rx_avail), 48'd0);
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        watch_idle(400, lows);
        chk("R1 parked write discarded", 48'(lows), 48'd0);

        // R11 external clock source, full duplex with odd parity, two stops.
        set_cfg(2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
        nb = frame_len(1, 1, 1);
        write_tx(8'hc3);
        fork
            grab_tx(1, nb, BIT_EXT, got);
            drive_rx(mk_frame(1, 1, 1, 1, 8'h96), nb, BIT_EXT);
        join
        repeat (6) @(negedge clk);
        chk("R11 ext tx frame", got, 48'(mk_frame(1, 1, 1, 1, 8'hc3)));
        expect_rx("R11 ext rx byte", 8'h96);
        chk("R11 no errors", 48'({err_parity, err_frame, err_overrun}), 48'd0);

        summary();
        $finish;
    end

endmodule